// File: doc/BRIEF.md
# Firmware System-Control Register Bank

This block is a small register bank that firmware reaches over a simple byte-lane bus. It offers system-control functions that an operating system does not need but boot and test code does. A write to the halt register stops the system and records an exit code. Reads return the index of the processor that issued the read, or the number of processors in the system. A write to the interrupt register drives a level onto one of the per-processor interrupt lines.

The register offset is the low six bits of the bus address, and each register occupies one 32-bit word. Byte lane 0 is `req_wdata[7:0]` and lane 1 is `req_wdata[15:8]`. Read data comes back registered one cycle after the request, in lane 0, with every other bit zero. Other blocks own the remaining words of the map. Here those words read as zero and ignore writes.

Top module: `fw_sysctl_regs`

## Requirements
- R1: The register offset is `req_addr & 6'h3f` and its word index is `offset[5:2]`. Address bits above bit 5 and offset bits [1:0] have no effect on decoding.
- R2: A write to word 0 (offset 0x00) with byte enable 0 set raises `halt_o`, and `exit_code_o` takes `req_wdata[7:0]`, both from the cycle after the write. If byte enable 0 is clear, the write has no effect.
- R3: `halt_o` stays high until reset. Once it is high, later halt writes leave `exit_code_o` unchanged.
- R4: A read of word 1 (offset 0x04) returns `req_cpu`, zero-extended, in `rsp_rdata[7:0]`.
- R5: A read of word 3 (offset 0x0C) returns `CFG_CPU_COUNT`. If `CFG_CPU_COUNT` is 0 (no count configured), it returns 1.
- R6: A write to word 2 (offset 0x08) with byte enable 0 set selects line `req_wdata[7:0]`. That line becomes 1 if byte enable 1 is set and `req_wdata[15:8]` is nonzero, and 0 otherwise. The result appears on `irq_o` in the cycle after the write. If byte enable 0 is clear, the write has no effect.
- R7: Each interrupt line keeps its level until it is written again. A write to one line leaves all other lines unchanged.
- R8: An interrupt write whose line number is `NUM_CPUS` or greater leaves `irq_o` unchanged.
- R9: Reads of every word other than 1 and 3 (including the write-only words 0 and 2) return all zeros. Writes to those other words change no output.
- R10: `rsp_valid` is high for exactly the one cycle after each read request, and it never rises after a write.
- R11: After reset, `halt_o`, `exit_code_o`, `irq_o`, `rsp_valid` and `rsp_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | DATA_W/8 | Byte-lane enables for writes |
| req_wdata | input | DATA_W | Write data |
| req_cpu | input | CPU_ID_W | Index of the requesting processor |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| halt_o | output | 1 | Sticky halt request |
| exit_code_o | output | 8 | Captured exit code |
| irq_o | output | NUM_CPUS | Per-processor interrupt levels |

## Verification
The in-RTL assertions check several rules on every cycle. Halt is sticky, and the exit code is frozen once halt is set. Interrupt lines change only on an in-range interrupt write. A response follows each read, and only a read. Unmapped reads return zero, and the count register never reads zero. The bench's scenarios are needed to show the actual values. These include the line a store selects, the level a one-byte store produces, address aliasing through the offset mask, the processor index returned to each requester, and both count variants.

// File: rtl/fw_sysctl_pkg.sv
package fw_sysctl_pkg;

   localparam int OFFS_W   = 6;
   localparam int WORD_W   = 4;
   localparam logic [OFFS_W-1:0] OFFS_MASK = 6'h3f;

   typedef enum logic [WORD_W-1:0] {
      W_HALT  = 4'd0,
      W_CPUID = 4'd1,
      W_IRQ   = 4'd2,
      W_NCPU  = 4'd3
   } word_e;

   function automatic logic [WORD_W-1:0] word_of(input logic [OFFS_W-1:0] offs);
      logic [OFFS_W-1:0] m;
      m = offs & OFFS_MASK;
      return m[OFFS_W-1:2];
   endfunction

endpackage

// File: rtl/fw_sysctl_decode.sv
module fw_sysctl_decode
   import fw_sysctl_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   localparam int BE_W  = DATA_W / 8
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              wr_halt,
   output logic [7:0]        halt_byte,
   output logic              wr_irq,
   output logic [7:0]        irq_port,
   output logic              irq_level,
   output logic              rd_fire,
   output logic [WORD_W-1:0] rd_word,
   output logic              rd_mapped
);

   logic [OFFS_W-1:0] offs;
   logic [WORD_W-1:0] word;
   logic              wr_fire;
   logic              lane0_on;
   logic              lane1_on;

   assign offs     = req_addr[OFFS_W-1:0];
   assign word     = word_of(offs);
   assign wr_fire  = req_valid && req_write;
   assign lane0_on = req_be[0];
   assign lane1_on = req_be[1];

   always_comb begin
      wr_halt   = 1'b0;
      wr_irq    = 1'b0;
      halt_byte = req_wdata[7:0];
      irq_port  = req_wdata[7:0];
      irq_level = lane1_on && (req_wdata[15:8] != 8'd0);
      if (wr_fire && lane0_on) begin
         case (word)
            W_HALT:  wr_halt = 1'b1;
            W_IRQ:   wr_irq  = 1'b1;
            default: ;
         endcase
      end
   end

   assign rd_fire = req_valid && !req_write;
   assign rd_word = word;

   always_comb begin
      case (word)
         W_CPUID, W_NCPU: rd_mapped = 1'b1;
         default:         rd_mapped = 1'b0;
      endcase
   end

   // R1: write strobes must never both fire for one request
   always_comb begin
      assert_one_target_R1: assert (!(wr_halt && wr_irq));
   end

endmodule

// File: rtl/fw_sysctl_halt.sv
module fw_sysctl_halt #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_halt,
   input  logic [CODE_W-1:0] halt_byte,
   output logic              halt_o,
   output logic [CODE_W-1:0] exit_code_o
);

   logic              halted_q;
   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         code_q   <= '0;
      end else if (wr_halt && !halted_q) begin
         halted_q <= 1'b1;
         code_q   <= halt_byte;
      end
   end

   assign halt_o      = halted_q;
   assign exit_code_o = code_q;

   assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |=> halt_o);

   assert_code_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |=> $stable(exit_code_o));

   assert_halt_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_o && wr_halt) |=> (halt_o && exit_code_o == $past(halt_byte)));

   assert_halt_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_o && !wr_halt) |=> !halt_o);

endmodule

// File: rtl/fw_sysctl_irq_bank.sv
module fw_sysctl_irq_bank #(
   parameter int NUM_LINES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_irq,
   input  logic [7:0]           irq_port,
   input  logic                 irq_level,
   output logic [NUM_LINES-1:0] irq_o
);

   logic [NUM_LINES-1:0] line_q;
   logic                 in_range;

   assign in_range = int'(irq_port) < NUM_LINES;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic hit;
      assign hit = wr_irq && (irq_port == 8'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) line_q[i] <= 1'b0;
         else if (hit) line_q[i] <= irq_level;
      end
   end

   assign irq_o = line_q;

   assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_irq |=> $stable(irq_o));

   assert_irq_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_irq && !in_range) |=> $stable(irq_o));

   assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_irq |=> $countones(irq_o ^ $past(irq_o)) <= 1);

endmodule

// File: rtl/fw_sysctl_rdmux.sv
module fw_sysctl_rdmux
   import fw_sysctl_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int CPU_ID_W      = 2,
   parameter int CFG_CPU_COUNT = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_fire,
   input  logic [WORD_W-1:0]   rd_word,
   input  logic [CPU_ID_W-1:0] req_cpu,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata
);

   logic [7:0]        cpu_byte;
   logic [7:0]        cnt_byte;
   logic [7:0]        sel_byte;
   logic [DATA_W-1:0] rdata_d;
   logic              vld_q;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      cpu_byte = '0;
      cpu_byte[CPU_ID_W-1:0] = req_cpu;
   end

   if (CFG_CPU_COUNT == 0) begin : g_cnt_default
      assign cnt_byte = 8'd1;
   end else begin : g_cnt_cfg
      assign cnt_byte = 8'(CFG_CPU_COUNT);
   end

   always_comb begin
      case (rd_word)
         W_CPUID: sel_byte = cpu_byte;
         W_NCPU:  sel_byte = cnt_byte;
         default: sel_byte = 8'd0;
      endcase
      rdata_d = '0;
      rdata_d[7:0] = sel_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         vld_q <= rd_fire;
         if (rd_fire) rdata_q <= rdata_d;
      end
   end

   assign rsp_valid = vld_q;
   assign rsp_rdata = rdata_q;

   assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> rsp_valid);

   assert_rsp_only_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fire |=> !rsp_valid);

   assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && rd_word == W_NCPU) |=> (rsp_rdata[7:0] != 8'd0));

   assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_rdata[DATA_W-1:8] == '0));

endmodule

// File: rtl/fw_sysctl_regs.sv
module fw_sysctl_regs
   import fw_sysctl_pkg::*;
#(
   parameter int NUM_CPUS      = 4,
   parameter int CFG_CPU_COUNT = 0,
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 32,
   localparam int BE_W         = DATA_W / 8,
   localparam int CPU_ID_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [BE_W-1:0]     req_be,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [CPU_ID_W-1:0] req_cpu,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                halt_o,
   output logic [7:0]          exit_code_o,
   output logic [NUM_CPUS-1:0] irq_o
);

   if (NUM_CPUS < 1 || NUM_CPUS > 256) begin : g_bad_cpus
      $error("NUM_CPUS must lie in 1..256");
   end
   if (CFG_CPU_COUNT < 0 || CFG_CPU_COUNT > 255) begin : g_bad_cnt
      $error("CFG_CPU_COUNT must lie in 0..255");
   end
   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (ADDR_W < OFFS_W) begin : g_bad_addr
      $error("ADDR_W must cover the register offset");
   end

   logic              wr_halt;
   logic [7:0]        halt_byte;
   logic              wr_irq;
   logic [7:0]        irq_port;
   logic              irq_level;
   logic              rd_fire;
   logic [WORD_W-1:0] rd_word;
   logic              rd_mapped;

   fw_sysctl_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .req_wdata (req_wdata),
      .wr_halt   (wr_halt),
      .halt_byte (halt_byte),
      .wr_irq    (wr_irq),
      .irq_port  (irq_port),
      .irq_level (irq_level),
      .rd_fire   (rd_fire),
      .rd_word   (rd_word),
      .rd_mapped (rd_mapped)
   );

   fw_sysctl_halt #(.CODE_W(8)) u_halt (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_halt     (wr_halt),
      .halt_byte   (halt_byte),
      .halt_o      (halt_o),
      .exit_code_o (exit_code_o)
   );

   fw_sysctl_irq_bank #(.NUM_LINES(NUM_CPUS)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_irq    (wr_irq),
      .irq_port  (irq_port),
      .irq_level (irq_level),
      .irq_o     (irq_o)
   );

   fw_sysctl_rdmux #(
      .DATA_W        (DATA_W),
      .CPU_ID_W      (CPU_ID_W),
      .CFG_CPU_COUNT (CFG_CPU_COUNT)
   ) u_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_fire   (rd_fire),
      .rd_word   (rd_word),
      .req_cpu   (req_cpu),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && !rd_mapped) |=> (rsp_rdata == '0));

   assert_write_no_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rsp_valid);

   assert_cpuid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && rd_word == W_CPUID) |=> (rsp_rdata[7:0] == 8'($past(req_cpu))));

endmodule

// File: tb/fw_sysctl_regs_tb.sv
`timescale 1ns/1ps
module fw_sysctl_regs_tb;

   localparam int NCPU = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic [1:0]  req_cpu = '0;
   logic        rsp_valid, rsp_valid_c;
   logic [31:0] rsp_rdata, rsp_rdata_c;
   logic        halt_o, halt_c;
   logic [7:0]  exit_code_o, code_c;
   logic [3:0]  irq_o, irq_c;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   fw_sysctl_regs #(.NUM_CPUS(NCPU), .CFG_CPU_COUNT(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_cpu(req_cpu),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .halt_o(halt_o),
      .exit_code_o(exit_code_o), .irq_o(irq_o));

   fw_sysctl_regs #(.NUM_CPUS(NCPU), .CFG_CPU_COUNT(3)) u_dut_cfg (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_cpu(req_cpu),
      .rsp_valid(rsp_valid_c), .rsp_rdata(rsp_rdata_c), .halt_o(halt_c),
      .exit_code_o(code_c), .irq_o(irq_c));

   // {write, addr[15:0], be[3:0], wdata[31:0], cpu[1:0], expect[31:0]}
   // expect = rsp_rdata for reads, irq_o for writes
   localparam int NV = 14;
   localparam logic [86:0] VEC [NV] = '{
      {1'b0, 16'h0004, 4'h0, 32'h0,      2'd2, 32'h2},
      {1'b0, 16'h0044, 4'h0, 32'h0,      2'd3, 32'h3},
      {1'b0, 16'h000C, 4'h0, 32'h0,      2'd0, 32'h1},
      {1'b0, 16'h0010, 4'h0, 32'h0,      2'd1, 32'h0},
      {1'b0, 16'h0008, 4'h0, 32'h0,      2'd1, 32'h0},
      {1'b1, 16'h0008, 4'h3, 32'h0102,   2'd0, 32'h4},
      {1'b1, 16'h0008, 4'h3, 32'h8000,   2'd0, 32'h5},
      {1'b1, 16'h0048, 4'h3, 32'h0101,   2'd0, 32'h7},
      {1'b1, 16'h0008, 4'h1, 32'hFF02,   2'd0, 32'h3},
      {1'b1, 16'h0008, 4'h3, 32'h0104,   2'd0, 32'h3},
      {1'b1, 16'h0008, 4'h2, 32'h0103,   2'd0, 32'h3},
      {1'b1, 16'h000A, 4'h3, 32'h0103,   2'd0, 32'hB},
      {1'b1, 16'h0010, 4'hF, 32'h0101,   2'd0, 32'hB},
      {1'b0, 16'h003C, 4'h0, 32'h0,      2'd2, 32'h0}
   };

   function automatic string tag_of(input int i);
      case (i)
         0: return "R4";
         1: return "R1";
         2: return "R5";
         3, 4, 13: return "R9";
         5, 6, 8: return "R6";
         7, 11: return "R1";
         9: return "R8";
         10: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // drive at negedge, release at next negedge; registered results are then visible
   task automatic bus_op(input logic wr, input logic [15:0] a, input logic [3:0] be,
                         input logic [31:0] wd, input logic [1:0] cpu);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be;
      req_wdata = wd; req_cpu = cpu;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_be = '0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog R10 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 halt", {31'd0, halt_o}, 32'd0);
      chk("R11 code", {24'd0, exit_code_o}, 32'd0);
      chk("R11 irq", {28'd0, irq_o}, 32'd0);
      chk("R11 rsp", {31'd0, rsp_valid}, 32'd0);
      chk("R11 rdata", rsp_rdata, 32'd0);

      for (int i = 0; i < NV; i++) begin
         logic [86:0] v;
         v = VEC[i];
         bus_op(v[86], v[85:70], v[69:66], v[65:34], v[33:32]);
         if (v[86]) begin
            chk({tag_of(i), " irq"}, {28'd0, irq_o}, v[31:0]);
            chk("R10 no rsp on write", {31'd0, rsp_valid}, 32'd0);
         end else begin
            chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
            chk({tag_of(i), " rdata"}, rsp_rdata, v[31:0]);
         end
      end
      @(negedge clk);
      chk("R10 single pulse", {31'd0, rsp_valid}, 32'd0);
      chk("R7 lines held", {28'd0, irq_o}, 32'hB);

      // R5 configured count variant
      bus_op(1'b0, 16'h000C, 4'h0, 32'h0, 2'd1);
      chk("R5 configured count", rsp_rdata_c, 32'd3);
      chk("R5 default count", rsp_rdata, 32'd1);

      // R2 lane 0 disabled: no halt
      bus_op(1'b1, 16'h0000, 4'h2, 32'h0000_5A5A, 2'd0);
      chk("R2 lane0 off", {31'd0, halt_o}, 32'd0);
      // R9 write to unmapped word: no halt
      bus_op(1'b1, 16'h0014, 4'hF, 32'h0000_0077, 2'd0);
      chk("R9 unmapped write", {31'd0, halt_o}, 32'd0);
      // R2 halt write
      bus_op(1'b1, 16'h0040, 4'h1, 32'h0000_005A, 2'd0);
      chk("R2 halt", {31'd0, halt_o}, 32'd1);
      chk("R2 code", {24'd0, exit_code_o}, 32'h5A);
      // R3 sticky, code frozen
      bus_op(1'b1, 16'h0000, 4'h1, 32'h0000_0033, 2'd0);
      repeat (4) @(negedge clk);
      chk("R3 halt sticky", {31'd0, halt_o}, 32'd1);
      chk("R3 code frozen", {24'd0, exit_code_o}, 32'h5A);
      // R9 halt word reads zero
      bus_op(1'b0, 16'h0000, 4'h0, 32'h0, 2'd3);
      chk("R9 halt word read", rsp_rdata, 32'd0);

      // R11 reset clears everything
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R11 halt after reset", {31'd0, halt_o}, 32'd0);
      chk("R11 code after reset", {24'd0, exit_code_o}, 32'd0);
      chk("R11 irq after reset", {28'd0, irq_o}, 32'd0);

      // R6 highest valid line, R8 line 255
      bus_op(1'b1, 16'h0008, 4'h3, 32'h0000_0103, 2'd0);
      chk("R6 top line", {28'd0, irq_o}, 32'h8);
      bus_op(1'b1, 16'h0008, 4'h3, 32'h0000_00FF, 2'd0);
      chk("R8 line 255", {28'd0, irq_o}, 32'h8);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule